// File: doc/BRIEF.md
# Serial Flash Write-Protection Guard

This block is the protection logic of a small serial flash. It keeps a four-bit status field (a status-lock bit and a three-bit protect level) and a write-enable latch, and it watches an active-low guard pin. Commands arrive already decoded, one per cycle, as a strobe with an opcode, a target byte address and a four-bit status value. For each strobe the block decides whether to accept or reject the command. It then updates the status field and the latch to match.

Status writes need the latch. They are also refused while the block is hardware-locked, which is when the lock bit is 1 and the guard pin is low. The locked state can be entered in either order: set the lock bit while the pin is already low, or drop the pin after the lock bit is set. It is left only by raising the pin. Program and erase commands need the latch. They are refused when the region they touch reaches into the top part of the array chosen by the protect level.

Top module: `flash_guard`

## Requirements
- R1: After a synchronous active-high reset, the lock bit, protect level, latch, accept, reject and hardware-lock outputs are all 0.
- R2: Opcode 0 (set latch) and opcode 1 (clear latch) are always accepted; they set and clear the write-enable latch respectively.
- R3: With the lock bit at 0, a status write (opcode 2) is accepted exactly when the latch is set, at either guard-pin level.
- R4: With the lock bit at 1 and the guard pin high, a status write is accepted exactly when the latch is set.
- R5: With the lock bit at 1 and the guard pin low, every status write is rejected, and the lock bit, protect level and latch keep their values.
- R6: The hardware-lock output equals (lock bit AND guard pin low) as held one cycle earlier. It can be entered in either order and is left only by raising the pin.
- R7: The protect level L (1..7) guards addresses at or above SIZE - SIZE/2^(7-L). Level 0 guards nothing and level 7 guards everything. Page program (opcode 3), sector erase (opcode 4) and block erase (opcode 5) are rejected when the last byte of their aligned region (256 B, 4 KiB, 64 KiB) is guarded.
- R8: Program and erase commands with the latch clear are rejected. An accepted status write, program or erase clears the latch. A rejected command leaves the latch unchanged.
- R9: Chip erase (opcode 6) is accepted only when the latch is set and the protect level is 0.
- R10: Every strobe gives exactly one of accept or reject, high for one cycle, in the cycle after the strobe. No strobe gives neither. Opcode 7 is always rejected.
- R11: In an accepted status write, status value bit 3 becomes the lock bit and bits 2:0 become the protect level. These are visible on the outputs in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| guard_n | input | 1 | Guard pin, low asks for hardware locking |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 3 | Decoded opcode |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 4 | Status value for a status write |
| acc_o | output | 1 | Command accepted pulse |
| rej_o | output | 1 | Command rejected pulse |
| lock_o | output | 1 | Status lock bit |
| level_o | output | 3 | Protect level |
| wel_o | output | 1 | Write-enable latch |
| hw_lock_o | output | 1 | Hardware-locked indication |

## Verification
The hardest state to reach is the hardware lock, because it needs the lock bit already set, the pin dropped and a latched status write attempted. Only then does the refusal show. The bench reaches it in both orders: it writes the lock bit with the pin high and then drops the pin, and it also drops the pin first and writes the lock bit while the lock bit is still 0. A full sweep over lock bit, pin level, latch state and all 16 status values checks the refusal and the frozen fields. The range rule is swept at both edges of every 2 KiB slice, for all eight levels and all three region sizes.

// File: rtl/fguard_pkg.sv
package fguard_pkg;
  typedef enum logic [2:0] {
    OP_WEL_SET = 3'd0,
    OP_WEL_CLR = 3'd1,
    OP_STAT_WR = 3'd2,
    OP_PROG    = 3'd3,
    OP_SECT    = 3'd4,
    OP_BLOCK   = 3'd5,
    OP_CHIP    = 3'd6,
    OP_RSVD    = 3'd7
  } fg_op_e;

  localparam int LEVEL_W = 3;
  localparam int REGIONS = 3;
endpackage

// File: rtl/fg_range_check.sv
module fg_range_check #(
  parameter int ADDR_W  = 17,
  parameter int LEVEL_W = 3
) (
  input  logic [LEVEL_W-1:0] level,
  input  logic [ADDR_W-1:0]  last_addr,
  output logic               hit
);
  localparam int TOP = (1 << LEVEL_W) - 1;
  localparam logic [ADDR_W:0] SIZE = {1'b1, {ADDR_W{1'b0}}};

  logic [ADDR_W:0] span;
  logic [ADDR_W:0] floor_addr;

  always_comb begin
    span       = SIZE >> (TOP - int'(level));
    floor_addr = SIZE - span;
    if (level == '0) hit = 1'b0;
    else             hit = ({1'b0, last_addr} >= floor_addr);
  end
endmodule

// File: rtl/fg_decide.sv
module fg_decide
  import fguard_pkg::*;
#(
  parameter int LEVEL_W = 3
) (
  input  logic               valid,
  input  logic [2:0]         op,
  input  logic               lock,
  input  logic [LEVEL_W-1:0] level,
  input  logic               wel,
  input  logic               guard_n,
  input  logic [REGIONS-1:0] region_hit,
  output logic               accept,
  output logic               reject,
  output logic               wel_set,
  output logic               wel_clr,
  output logic               stat_we
);
  fg_op_e opc;
  logic   hw_locked;

  always_comb begin
    opc       = fg_op_e'(op);
    hw_locked = lock & ~guard_n;
    accept    = 1'b0;
    wel_set   = 1'b0;
    wel_clr   = 1'b0;
    stat_we   = 1'b0;
    if (valid) begin
      unique case (opc)
        OP_WEL_SET: begin accept = 1'b1; wel_set = 1'b1; end
        OP_WEL_CLR: begin accept = 1'b1; wel_clr = 1'b1; end
        OP_STAT_WR: if (wel && !hw_locked) begin
          accept = 1'b1; stat_we = 1'b1; wel_clr = 1'b1;
        end
        OP_PROG:  if (wel && !region_hit[0]) begin accept = 1'b1; wel_clr = 1'b1; end
        OP_SECT:  if (wel && !region_hit[1]) begin accept = 1'b1; wel_clr = 1'b1; end
        OP_BLOCK: if (wel && !region_hit[2]) begin accept = 1'b1; wel_clr = 1'b1; end
        OP_CHIP:  if (wel && level == '0)    begin accept = 1'b1; wel_clr = 1'b1; end
        default:  accept = 1'b0;
      endcase
    end
    reject = valid & ~accept;
  end
endmodule

// File: rtl/fg_status_reg.sv
module fg_status_reg #(
  parameter int LEVEL_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stat_we,
  input  logic [LEVEL_W:0]   stat_in,
  input  logic               wel_set,
  input  logic               wel_clr,
  output logic               lock_q,
  output logic [LEVEL_W-1:0] level_q,
  output logic               wel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q  <= 1'b0;
      level_q <= '0;
      wel_q   <= 1'b0;
    end else begin
      if (stat_we) begin
        lock_q  <= stat_in[LEVEL_W];
        level_q <= stat_in[LEVEL_W-1:0];
      end
      if (wel_set)      wel_q <= 1'b1;
      else if (wel_clr) wel_q <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fguard_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int PAGE_W   = 8,
  parameter int SECTOR_W = 12,
  parameter int BLOCK_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              guard_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [3:0]        cmd_data,
  output logic              acc_o,
  output logic              rej_o,
  output logic              lock_o,
  output logic [2:0]        level_o,
  output logic              wel_o,
  output logic              hw_lock_o
);
  localparam int REGION_W [REGIONS] = '{PAGE_W, SECTOR_W, BLOCK_W};

  logic [REGIONS-1:0] region_hit;
  logic accept, reject, wel_set, wel_clr, stat_we;

  for (genvar g = 0; g < REGIONS; g++) begin : g_region
    localparam logic [ADDR_W-1:0] MASK = ADDR_W'((1 << REGION_W[g]) - 1);
    logic [ADDR_W-1:0] last_addr;
    assign last_addr = cmd_addr | MASK;
    fg_range_check #(.ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W)) u_rng (
      .level(level_o), .last_addr(last_addr), .hit(region_hit[g])
    );
  end

  fg_decide #(.LEVEL_W(LEVEL_W)) u_dec (
    .valid(cmd_valid), .op(cmd_op), .lock(lock_o), .level(level_o),
    .wel(wel_o), .guard_n(guard_n), .region_hit(region_hit),
    .accept(accept), .reject(reject), .wel_set(wel_set),
    .wel_clr(wel_clr), .stat_we(stat_we)
  );

  fg_status_reg #(.LEVEL_W(LEVEL_W)) u_sr (
    .clk(clk), .rst(rst), .stat_we(stat_we), .stat_in(cmd_data),
    .wel_set(wel_set), .wel_clr(wel_clr),
    .lock_q(lock_o), .level_q(level_o), .wel_q(wel_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o     <= 1'b0;
      rej_o     <= 1'b0;
      hw_lock_o <= 1'b0;
    end else begin
      acc_o     <= accept;
      rej_o     <= reject;
      hw_lock_o <= lock_o & ~guard_n;
    end
  end
endmodule

// File: rtl/fg_checker.sv
module fg_checker (
  input logic       clk,
  input logic       rst,
  input logic       guard_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       acc_o,
  input logic       rej_o,
  input logic       lock_o,
  input logic [2:0] level_o,
  input logic       wel_o,
  input logic       hw_lock_o
);
  // R10
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> (acc_o ^ rej_o));
  // R10
  quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (!acc_o && !rej_o));
  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd0) |=> (acc_o && wel_o));
  // R5
  hw_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd2 && lock_o && !guard_n)
      |=> (rej_o && $stable(lock_o) && $stable(level_o) && $stable(wel_o)));
  // R8
  need_wel_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op >= 3'd3 && cmd_op <= 3'd6 && !wel_o) |=> rej_o);
  // R6
  hw_flag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hw_lock_o == $past(lock_o && !guard_n)));
endmodule

bind flash_guard fg_checker u_chk (
  .clk(clk), .rst(rst), .guard_n(guard_n), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .acc_o(acc_o), .rej_o(rej_o), .lock_o(lock_o),
  .level_o(level_o), .wel_o(wel_o), .hw_lock_o(hw_lock_o)
);

// File: tb/tb_flash_guard.sv
module tb_flash_guard;
  localparam int AW = 17;
  localparam int SIZE = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic guard_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [3:0] cmd_data = '0;
  logic acc_o, rej_o, lock_o, wel_o, hw_lock_o;
  logic [2:0] level_o;

  int checks = 0;
  int failures = 0;
  bit m_lock = 0;
  bit m_wel = 0;
  int m_level = 0;

  always #5 clk = ~clk;

  flash_guard #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .guard_n(guard_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .acc_o(acc_o), .rej_o(rej_o), .lock_o(lock_o), .level_o(level_o),
    .wel_o(wel_o), .hw_lock_o(hw_lock_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit guarded(input int level, input int last);
    if (level == 0) return 0;
    return last >= (SIZE - (SIZE >> (7 - level)));
  endfunction

  task automatic do_cmd(input int op, input int addr, input int data);
    bit ea;
    string tag;
    int last;
    ea = 0;
    case (op)
      0: begin ea = 1; tag = "R2"; end
      1: begin ea = 1; tag = "R2"; end
      2: begin
        ea = m_wel && !(m_lock && !guard_n);
        tag = !m_lock ? "R3" : (guard_n ? "R4" : "R5");
      end
      3, 4, 5: begin
        last = addr | ((op == 3) ? 255 : (op == 4) ? 4095 : 65535);
        ea = m_wel && !guarded(m_level, last);
        tag = m_wel ? "R7" : "R8";
      end
      6: begin ea = m_wel && m_level == 0; tag = "R9"; end
      default: begin ea = 0; tag = "R10"; end
    endcase
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = AW'(addr); cmd_data = 4'(data);
    @(negedge clk);
    cmd_valid = 0;
    if (ea) begin
      if (op == 0) m_wel = 1;
      else m_wel = 0;
      if (op == 2) begin m_lock = data[3]; m_level = data & 7; end
    end
    check(acc_o == ea && rej_o == !ea, {tag, " accept/R10"}, {acc_o, rej_o}, {ea, !ea});
    check(wel_o == m_wel, {tag, " latch/R8"}, wel_o, m_wel);
    check(lock_o == m_lock && level_o == 3'(m_level), {tag, " status/R11"},
          {lock_o, level_o}, {m_lock, 3'(m_level)});
  endtask

  task automatic set_status(input int data);
    guard_n = 1;
    do_cmd(0, 0, 0);
    do_cmd(2, 0, data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check({acc_o, rej_o, lock_o, level_o, wel_o, hw_lock_o} == '0, "R1", 
          {acc_o, rej_o, lock_o, level_o, wel_o, hw_lock_o}, 0);

    // R2 latch control
    do_cmd(0, 0, 0);
    do_cmd(0, 0, 0);
    do_cmd(1, 0, 0);
    do_cmd(1, 0, 0);

    // R3 R4 R5 R11 status-write sweep
    for (int pin = 0; pin < 2; pin++)
      for (int lk = 0; lk < 2; lk++)
        for (int w = 0; w < 2; w++)
          for (int d = 0; d < 16; d++) begin
            set_status((lk << 3) | ((d + 3) & 7));
            guard_n = pin[0];
            do_cmd(w ? 0 : 1, 0, 0);
            do_cmd(2, 0, d);
          end

    // R6 entry by lock then pin
    set_status(8);
    repeat (2) @(negedge clk);
    check(hw_lock_o == 0, "R6 pin high", hw_lock_o, 0);
    guard_n = 0;
    repeat (2) @(negedge clk);
    check(hw_lock_o == 1, "R6 lock-then-pin", hw_lock_o, 1);
    do_cmd(0, 0, 0);
    do_cmd(2, 0, 0);
    repeat (2) @(negedge clk);
    check(hw_lock_o == 1, "R6 sticky", hw_lock_o, 1);
    guard_n = 1;
    repeat (2) @(negedge clk);
    check(hw_lock_o == 0, "R6 exit", hw_lock_o, 0);
    do_cmd(2, 0, 0);
    // R6 entry by pin then lock
    guard_n = 0;
    do_cmd(0, 0, 0);
    do_cmd(2, 0, 8 | 5);
    @(negedge clk);
    check(hw_lock_o == 1, "R6 pin-then-lock", hw_lock_o, 1);
    guard_n = 1;
    set_status(0);

    // R7 R8 range sweep
    for (int lv = 0; lv < 8; lv++) begin
      set_status(lv);
      for (int op = 3; op < 6; op++)
        for (int i = 0; i < 64; i++)
          for (int e = 0; e < 2; e++) begin
            do_cmd(0, 0, 0);
            do_cmd(op, i * 2048 + e * 2047, 0);
          end
      do_cmd(1, 0, 0);
      do_cmd(3, 0, 0);
      do_cmd(4, 4096, 0);
      // R9 chip erase
      do_cmd(6, 0, 0);
      do_cmd(0, 0, 0);
      do_cmd(6, 0, 0);
    end

    // R10 reserved opcode and idle
    do_cmd(0, 0, 0);
    do_cmd(7, 0, 0);
    @(negedge clk);
    check(!acc_o && !rej_o, "R10 idle", {acc_o, rej_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule